// File: doc/BRIEF.md
# SPI Slave Burst Engine

This block is the slave-side receive and transmit engine of an SPI port. It watches the SPI clock, data-in and active-low select pins, brings them into the system clock domain, and shifts one bit per SPI clock while the select is asserted. It uses SPI mode 0 with the most significant bit first. Incoming bits are sampled on the rising SCLK edge. The outgoing bit changes on the falling edge.

The block decides when a burst is finished. There are two ways, chosen by a mode input. In counted mode the burst ends after a programmed number of bits, so several bursts can follow one another under a single select. In select-framed mode the burst ends when the select is released, so its length need not be known in advance. At the end of each burst the block pushes one received word into the receive queue and releases the transmit word it has just sent. Both happen in the same clock cycle. The queues themselves sit outside the block. The block sees them only through a valid/ready pair on each side.

Top module: `spi_burst_slave`

## Requirements
- R1: While the synchronized select is high (negated), SCLK and MOSI edges have no effect: no bit is captured, no word is pushed or released, and `miso_o` is held at 0.
- R2: With `frame_mode_i` = 0, a burst ends on the rising SCLK edge that brings the bit count to `burst_len_i` + 1. The pushed word holds the last min(N, 32) received bits, right-aligned, with the last bit in bit 0 and zeros above a short burst.
- R3: With `frame_mode_i` = 1, a burst ends on the release edge of the select, provided that at least one bit was clocked. `burst_len_i` has no effect in this mode. A select pulse with no SCLK edges advances nothing.
- R4: The select assertion edge never pushes or releases a word. It clears the bit count and the receive shift register, and it loads the head transmit word.
- R5: At every burst end, `tx_pop_o` pulses in the same cycle as `rx_push_o`, provided that a transmit word was taken for that burst.
- R6: `miso_o` presents bit 31 of the loaded word before the first rising edge and advances one bit on each falling SCLK edge. After 32 bits it sends zeros.
- R7: In counted mode, when a burst ends with the select still asserted, the next transmit word is loaded on the following falling SCLK edge and the next burst starts counting from zero.
- R8: In counted mode, releasing the select before the count is reached discards the partial word and advances neither queue. The same transmit word is sent again at the next assertion.
- R9: If no transmit word is available when one is loaded, zeros are shifted out. `tx_underflow_o` is set once a bit is actually clocked and stays set until reset, and no transmit release is signalled for that burst.
- R10: If `rx_ready_i` is low at a burst end, the received word is dropped and `rx_overflow_o` is set and stays set until reset. The transmit word is still released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI clock pin, asynchronous |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| burst_len_i | input | 12 | Burst length minus one, used in counted mode |
| frame_mode_i | input | 1 | 0 = counted bursts, 1 = bursts framed by the select |
| tx_data_i | input | 32 | Head word of the transmit queue |
| tx_valid_i | input | 1 | Transmit queue holds a word |
| tx_pop_o | output | 1 | One-cycle pulse: the head transmit word is used up |
| rx_data_o | output | 32 | Received word |
| rx_push_o | output | 1 | One-cycle pulse: write `rx_data_o` into the receive queue |
| rx_ready_i | input | 1 | Receive queue has space |
| tx_underflow_o | output | 1 | Sticky: bits were clocked with no transmit word |
| rx_overflow_o | output | 1 | Sticky: a received word was dropped |

## Verification
A pin edge passes through two synchronizer flops and one edge-history flop, so the action is registered on the third system clock edge after the pin change. `rx_push_o` and `tx_pop_o` therefore pulse about three cycles after the final rising SCLK edge in counted mode, or after the release of the select in select-framed mode. `miso_o` changes about three cycles after a falling SCLK edge or a select assertion. The bench holds each SCLK phase for six system cycles and samples MISO at the end of the phase. It records pushes and releases with their cycle numbers as they happen, and checks the queue counts and flags only after ten or more idle cycles, so none of these latencies can fall outside a sampled window.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    localparam int WORD_W_DEF = 32;
    localparam int LEN_W_DEF  = 12;

    // Commands from the burst controller to the shift datapath
    typedef struct packed {
        logic clr_rx;    // zero the receive shifter
        logic cap;       // shift MOSI into the receive shifter
        logic load_tx;   // load the head transmit word (or zeros)
        logic shift_tx;  // advance the transmit shifter by one bit
    } shift_cmd_t;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.s2;

endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
    import spi_slv_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  shift_cmd_t        cmd_i,
    input  logic              tx_valid_i,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              mosi_i,
    input  logic              active_i,
    output logic              tx_msb_o,
    output logic [WORD_W-1:0] rx_next_o
);

    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } shf_st_t;

    shf_st_t shf_d, shf_q;
    logic [WORD_W-1:0] rx_next;

    always_comb begin
        shf_d   = shf_q;
        rx_next = cmd_i.cap ? {shf_q.rx[WORD_W-2:0], mosi_i} : shf_q.rx;
        shf_d.rx = cmd_i.clr_rx ? '0 : rx_next;
        if (cmd_i.load_tx) begin
            shf_d.tx = tx_valid_i ? tx_data_i : '0;
        end else if (cmd_i.shift_tx) begin
            shf_d.tx = {shf_q.tx[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign tx_msb_o  = shf_q.tx[WORD_W-1];
    assign rx_next_o = rx_next;

    // R1: with the select negated the receive shifter is frozen
    a_r1_rx_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !cmd_i.clr_rx) |=> $stable(shf_q.rx));

    // R1: with the select negated the transmit shifter is frozen
    a_r1_tx_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> $stable(shf_q.tx));

endmodule

// File: rtl/spi_slv_ctl.sv
module spi_slv_ctl
    import spi_slv_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF,
    parameter int LEN_W  = LEN_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_mode_i,
    input  logic [LEN_W-1:0]  burst_len_i,
    input  logic              sclk_lvl_i,
    input  logic              ss_lvl_i,
    input  logic              tx_valid_i,
    input  logic              rx_ready_i,
    input  logic [WORD_W-1:0] rx_next_i,
    output shift_cmd_t        cmd_o,
    output logic              tx_pop_o,
    output logic              rx_push_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              tx_underflow_o,
    output logic              rx_overflow_o
);

    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              sclk_prv;
        logic              ss_prv;
        logic [CNT_W-1:0]  cnt;
        logic              reload;
        logic              took;
        logic              empty;
        logic              under;
        logic              over;
        logic              push;
        logic              pop;
        logic [WORD_W-1:0] word;
    } ctl_st_t;

    localparam ctl_st_t CTL_RST = '{ss_prv: 1'b1, default: '0};

    ctl_st_t    ctl_d, ctl_q;
    shift_cmd_t cmd;
    logic       active, ss_fall, ss_rise, sclk_rise, sclk_fall;
    logic       cap, drop, done;

    always_comb begin
        active    = !ss_lvl_i;
        ss_fall   = ctl_q.ss_prv && !ss_lvl_i;
        ss_rise   = !ctl_q.ss_prv && ss_lvl_i;
        sclk_rise = sclk_lvl_i && !ctl_q.sclk_prv;
        sclk_fall = !sclk_lvl_i && ctl_q.sclk_prv;
        cap       = sclk_rise && active && !ss_fall;
        drop      = sclk_fall && active && !ss_fall;
        done      = 1'b0;
        cmd       = '0;

        ctl_d          = ctl_q;
        ctl_d.sclk_prv = sclk_lvl_i;
        ctl_d.ss_prv   = ss_lvl_i;
        ctl_d.push     = 1'b0;
        ctl_d.pop      = 1'b0;

        if (ss_fall) begin
            // burst start: load word, reset count, never advance queues
            cmd.clr_rx   = 1'b1;
            cmd.load_tx  = 1'b1;
            ctl_d.cnt    = '0;
            ctl_d.reload = 1'b0;
            ctl_d.took   = tx_valid_i;
            ctl_d.empty  = !tx_valid_i;
        end else begin
            if (drop) begin
                if (ctl_q.reload) begin
                    cmd.load_tx  = 1'b1;
                    ctl_d.reload = 1'b0;
                    ctl_d.took   = tx_valid_i;
                    ctl_d.empty  = !tx_valid_i;
                end else begin
                    cmd.shift_tx = 1'b1;
                end
            end
            if (cap) begin
                cmd.cap = 1'b1;
                if (ctl_q.empty) begin
                    ctl_d.under = 1'b1;
                end
                if (!frame_mode_i) begin
                    if (ctl_q.cnt == {1'b0, burst_len_i}) begin
                        done         = 1'b1;
                        cmd.clr_rx   = 1'b1;
                        ctl_d.cnt    = '0;
                        ctl_d.reload = 1'b1;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end else if (ctl_q.cnt != CNT_MAX) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            if (ss_rise) begin
                // end of frame: completes only in select-framed mode
                if (frame_mode_i && ctl_q.cnt != '0) begin
                    done = 1'b1;
                end
                ctl_d.cnt    = '0;
                ctl_d.reload = 1'b0;
            end
        end

        if (done) begin
            ctl_d.pop  = ctl_q.took;
            ctl_d.took = 1'b0;
            if (rx_ready_i) begin
                ctl_d.push = 1'b1;
                ctl_d.word = rx_next_i;
            end else begin
                ctl_d.over = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_o          = cmd;
    assign tx_pop_o       = ctl_q.pop;
    assign rx_push_o      = ctl_q.push;
    assign rx_data_o      = ctl_q.word;
    assign tx_underflow_o = ctl_q.under;
    assign rx_overflow_o  = ctl_q.over;

    // R4: the select assertion edge restarts the bit count
    a_r4_start_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        ss_fall |=> (ctl_q.cnt == '0));

    // R4: the select assertion edge pushes and releases nothing
    a_r4_start_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        ss_fall |=> (!rx_push_o && !tx_pop_o));

    // R5: a transmit release only accompanies a burst end
    a_r5_pop_with_push: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_o |-> (rx_push_o || rx_overflow_o));

    // R8: a counted burst cut short by the select pushes nothing
    a_r8_no_push_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_mode_i && ss_rise) |=> !rx_push_o);

    // R9: underflow flag is sticky
    a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underflow_o |=> tx_underflow_o);

    // R10: overflow flag is sticky
    a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow_o |=> rx_overflow_o);

endmodule

// File: rtl/spi_burst_slave.sv
module spi_burst_slave
    import spi_slv_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF,
    parameter int LEN_W  = LEN_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              ss_n_i,
    output logic              miso_o,
    input  logic [LEN_W-1:0]  burst_len_i,
    input  logic              frame_mode_i,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_pop_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_push_o,
    input  logic              rx_ready_i,
    output logic              tx_underflow_o,
    output logic              rx_overflow_o
);

    localparam int PIN_N = 3;
    localparam logic [PIN_N-1:0] PIN_RST = 3'b100;   // select idles high

    logic [PIN_N-1:0] pins_sync;
    logic             sclk_s, mosi_s, ss_s, active;
    logic             tx_msb;
    logic [WORD_W-1:0] rx_next;
    shift_cmd_t        cmd;

    spi_slv_sync #(
        .W       (PIN_N),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ss_n_i, mosi_i, sclk_i}),
        .sync_o  (pins_sync)
    );

    assign sclk_s = pins_sync[0];
    assign mosi_s = pins_sync[1];
    assign ss_s   = pins_sync[2];
    assign active = !ss_s;

    spi_slv_ctl #(
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W)
    ) u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_mode_i   (frame_mode_i),
        .burst_len_i    (burst_len_i),
        .sclk_lvl_i     (sclk_s),
        .ss_lvl_i       (ss_s),
        .tx_valid_i     (tx_valid_i),
        .rx_ready_i     (rx_ready_i),
        .rx_next_i      (rx_next),
        .cmd_o          (cmd),
        .tx_pop_o       (tx_pop_o),
        .rx_push_o      (rx_push_o),
        .rx_data_o      (rx_data_o),
        .tx_underflow_o (tx_underflow_o),
        .rx_overflow_o  (rx_overflow_o)
    );

    spi_slv_shift #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .tx_valid_i (tx_valid_i),
        .tx_data_i  (tx_data_i),
        .mosi_i     (mosi_s),
        .active_i   (active),
        .tx_msb_o   (tx_msb),
        .rx_next_o  (rx_next)
    );

    assign miso_o = active & tx_msb;

endmodule

// File: tb/spi_burst_slave_tb_top.sv
module spi_burst_slave_tb_top;

    localparam int CLK_P = 10;
    localparam int H     = 6;     // system cycles per SCLK phase

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1;
    logic        miso;
    logic [11:0] blen = '0;
    logic        fmode = 1'b0;
    logic        rx_ready = 1'b1;
    logic        tx_pop, rx_push, under, over;
    logic [31:0] rx_data;

    logic [31:0] txm [0:15];
    int          tx_cnt = 0, tx_head = 0;
    logic        tx_valid;
    logic [31:0] tx_data;

    logic [31:0] push_log [0:15];
    int          push_n = 0, pop_n = 0, cyc = 0, push_cyc = -1, pop_cyc = -2;
    int          n_chk = 0, n_bad = 0;
    logic        finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign tx_valid = tx_head < tx_cnt;
    assign tx_data  = tx_valid ? txm[tx_head % 16] : 32'h0;

    spi_burst_slave dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sclk_i         (sclk),
        .mosi_i         (mosi),
        .ss_n_i         (ss_n),
        .miso_o         (miso),
        .burst_len_i    (blen),
        .frame_mode_i   (fmode),
        .tx_data_i      (tx_data),
        .tx_valid_i     (tx_valid),
        .tx_pop_o       (tx_pop),
        .rx_data_o      (rx_data),
        .rx_push_o      (rx_push),
        .rx_ready_i     (rx_ready),
        .tx_underflow_o (under),
        .rx_overflow_o  (over)
    );

    // queue models and event log
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rx_push) begin
            push_log[push_n % 16] <= rx_data;
            push_n   <= push_n + 1;
            push_cyc <= cyc;
        end
        if (tx_pop) begin
            pop_n   <= pop_n + 1;
            tx_head <= tx_head + 1;
            pop_cyc <= cyc;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic queue_tx(input logic [31:0] w);
        txm[tx_cnt % 16] = w;
        tx_cnt++;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ss_assert();
        @(negedge clk);
        ss_n = 1'b0;
    endtask

    task automatic ss_release();
        idle(H);
        ss_n = 1'b1;
        idle(2*H);
    endtask

    task automatic clock_bits(input logic [63:0] mo, input int n, output logic [63:0] mi);
        mi = '0;
        for (int i = 0; i < n; i++) begin
            mosi = mo[n-1-i];
            idle(H);
            mi = {mi[62:0], miso};
            sclk = 1'b1;
            idle(H);
            sclk = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 reset miso", {63'h0, miso}, 64'h0);
        chk("R5 reset pulses", {62'h0, rx_push, tx_pop}, 64'h0);
        chk("R9 reset flags", {62'h0, under, over}, 64'h0);
    endtask

    task automatic t_counted_byte();
        logic [63:0] mi;
        fmode = 1'b0; blen = 12'd7;
        queue_tx(32'hA5C3_0F11);
        ss_assert();
        clock_bits(64'h3C, 8, mi);
        ss_release();
        chk("R2 byte push count", 64'(push_n), 64'd1);
        chk("R2 byte data", {32'h0, push_log[0]}, 64'h3C);
        chk("R6 byte miso", mi, 64'hA5);
        chk("R5 pop count", 64'(pop_n), 64'd1);
        chk("R5 pop same cycle as push", 64'(pop_cyc), 64'(push_cyc));
    endtask

    task automatic t_back_to_back();
        logic [63:0] mi;
        blen = 12'd11;
        queue_tx(32'h9AB1_2345);
        queue_tx(32'h6D4F_0000);
        ss_assert();
        clock_bits(64'h5A3C7E, 24, mi);
        ss_release();
        chk("R7 two pushes", 64'(push_n), 64'd3);
        chk("R7 first word", {32'h0, push_log[1]}, 64'h5A3);
        chk("R7 second word", {32'h0, push_log[2]}, 64'hC7E);
        chk("R7 miso both words", mi, 64'h9AB6D4);
        chk("R5 two pops", 64'(pop_n), 64'd3);
    endtask

    task automatic t_abort();
        logic [63:0] mi;
        blen = 12'd15;
        queue_tx(32'hBEEF_1234);
        ss_assert();
        clock_bits(64'h15, 5, mi);
        ss_release();
        chk("R8 abort no push", 64'(push_n), 64'd3);
        chk("R8 abort no pop", 64'(pop_n), 64'd3);
        ss_assert();
        clock_bits(64'h1234, 16, mi);
        ss_release();
        chk("R8 word resent", mi, 64'hBEEF);
        chk("R8 clean word after abort", {32'h0, push_log[3]}, 64'h1234);
        chk("R8 single pop", 64'(pop_n), 64'd4);
    endtask

    task automatic t_idle_clocks();
        logic [63:0] mi;
        logic        seen = 1'b0;
        blen = 12'd3;
        queue_tx(32'h7000_0000);
        mosi = 1'b1;
        for (int i = 0; i < 10; i++) begin
            idle(H); sclk = 1'b1; seen = seen | miso;
            idle(H); sclk = 1'b0; seen = seen | miso;
        end
        idle(2*H);
        chk("R1 idle miso low", {63'h0, seen}, 64'h0);
        chk("R1 idle no push", 64'(push_n), 64'd4);
        chk("R1 idle no pop", 64'(pop_n), 64'd4);
        ss_assert();
        clock_bits(64'hB, 4, mi);
        ss_release();
        chk("R1 no stale bits", {32'h0, push_log[4]}, 64'hB);
        chk("R6 nibble miso", mi, 64'h7);
    endtask

    task automatic t_framed();
        logic [63:0] mi;
        fmode = 1'b1; blen = 12'd3;
        queue_tx(32'hCAFE_B0BA);
        ss_assert();
        clock_bits(64'hF00D5, 20, mi);
        idle(10);
        chk("R3 length ignored", 64'(push_n), 64'd5);
        ss_release();
        chk("R3 push on release", 64'(push_n), 64'd6);
        chk("R3 framed data", {32'h0, push_log[5]}, 64'hF00D5);
        chk("R6 framed miso", mi, 64'hCAFEB);
        chk("R5 framed pop same cycle", 64'(pop_cyc), 64'(push_cyc));
    endtask

    task automatic t_framed_long();
        logic [63:0] mi;
        queue_tx(32'h0123_4567);
        ss_assert();
        clock_bits(64'h12_3456_789A, 40, mi);
        ss_release();
        chk("R3 long data last 32", {32'h0, push_log[6]}, 64'h3456_789A);
        chk("R6 zeros after word", mi, 64'h01_2345_6700);
    endtask

    task automatic t_start_edge();
        ss_assert();
        idle(20);
        chk("R4 assert no push", 64'(push_n), 64'd7);
        chk("R4 assert no pop", 64'(pop_n), 64'd7);
        ss_release();
        chk("R3 empty frame no push", 64'(push_n), 64'd7);
        chk("R9 no underflow unclocked", {63'h0, under}, 64'h0);
    endtask

    task automatic t_counted_long();
        logic [63:0] mi;
        fmode = 1'b0; blen = 12'd40;
        queue_tx(32'hFFFF_FFFF);
        ss_assert();
        clock_bits(64'h1_2345_6789_AB, 41, mi);
        ss_release();
        chk("R2 41-bit push", 64'(push_n), 64'd8);
        chk("R2 41-bit data", {32'h0, push_log[7]}, 64'h4567_89AB);
        chk("R6 41-bit miso", mi, 64'h1FF_FFFF_FE00);
    endtask

    task automatic t_underflow();
        logic [63:0] mi;
        blen = 12'd7;
        ss_assert();
        clock_bits(64'h81, 8, mi);
        ss_release();
        chk("R9 zeros out", mi, 64'h0);
        chk("R9 flag set", {63'h0, under}, 64'h1);
        chk("R9 no pop", 64'(pop_n), 64'd8);
        chk("R9 rx still pushed", {32'h0, push_log[8]}, 64'h81);
    endtask

    task automatic t_overflow();
        logic [63:0] mi;
        queue_tx(32'h1357_9BDF);
        rx_ready = 1'b0;
        ss_assert();
        clock_bits(64'h66, 8, mi);
        ss_release();
        rx_ready = 1'b1;
        chk("R10 dropped", 64'(push_n), 64'd9);
        chk("R10 flag set", {63'h0, over}, 64'h1);
        chk("R10 tx still pops", 64'(pop_n), 64'd9);
        chk("R6 overflow miso", mi, 64'h13);
        chk("R9 underflow still set", {63'h0, under}, 64'h1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        idle(4);
        t_reset();
        t_counted_byte();
        t_back_to_back();
        t_abort();
        t_idle_clocks();
        t_framed();
        t_framed_long();
        t_start_edge();
        t_counted_long();
        t_underflow();
        t_overflow();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule